// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block receives a stereo PCM stream from a serial audio link and turns each frame into a pair of parallel words. It runs on the link's own bit clock. On each bit-clock edge it samples a serial data line and a frame clock. The frame clock is either a channel-select level or a once-per-frame sync pulse, depending on the framing chosen.

Static configuration inputs set the rest of the decoding. They choose one of four framings (MSB-first left-aligned, the common two-channel inter-chip framing, LSB-aligned right-justified, and pulse-synchronised time-multiplexed), one of four word lengths, and a 32-bit or 24-bit channel slot. They can also delay the frame clock by one bit clock and make the block sample on the falling edge of the bit clock instead of the rising one.

Each accepted frame gives two 24-bit words. Each word is left-aligned, with its unused low bits zero. The two words come with a one-cycle valid strobe, so downstream logic can take them in the cycle the strobe is high.

Top module: `serial_audio_rx`

## Requirements
- R1: The framing code `fmt_sel` selects 00 left-justified, 01 I2S, 10 right-justified and 11 DSP. Code 00, with length code 00, is the configuration a system gets by leaving both inputs at zero.
- R2: The length code `len_sel` gives the word length W: 00 gives 24 bits, 01 gives 20, 10 gives 18 and 11 gives 16. Each output word carries the received word in bits [23:24-W] and zeros below.
- R3: In left-justified framing, the bit sampled on the first active edge after a frame-clock change is the MSB. A high frame clock marks the left channel.
- R4: In I2S framing, the MSB is the bit sampled on the second active edge after a frame-clock change. A low frame clock marks the left channel.
- R5: In right-justified framing, the LSB of a channel's word is the last bit sampled before the frame clock changes. A high frame clock marks the left channel.
- R6: In DSP framing, a rising frame clock marks a frame. The left word's MSB is sampled on that edge, the right word follows with no gap, and bits after the right word's LSB are ignored.
- R7: `short_frame` selects a channel slot of 24 bit clocks (1) or 32 (0). In the three level-framed modes, a slot is accepted only if it lasts exactly that many bit clocks.
- R8: With `fs_lag` = 1, the frame clock is delayed by one bit clock before decoding, so every word position moves one bit later.
- R9: With `clk_flip` = 1, data and frame clock are sampled on the falling edge of `bclk`.
- R10: `word_valid` is high for exactly one cycle per accepted frame. In the level-framed modes it rises on the frame-clock edge that ends an accepted right slot, when the left slot just before it was also accepted. In DSP mode it rises on the cycle that samples the right word's LSB.
- R11: Bits that fall outside the W-bit word within a slot have no effect on the output words.
- R12: A frame with a short, long or missing slot gives no strobe, and both output words keep their previous values.
- R13: Reset clears both words and the strobe. The first slot after reset is never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sfs | input | 1 | Frame clock: channel select or sync pulse |
| sdata | input | 1 | Serial data, MSB first |
| fmt_sel | input | 2 | Framing code |
| len_sel | input | 2 | Word length code |
| short_frame | input | 1 | 1: 24-bit slots, 0: 32-bit slots |
| fs_lag | input | 1 | Delay frame clock by one bit clock |
| clk_flip | input | 1 | Sample on falling bit-clock edge |
| left_word | output | 24 | Left-aligned left channel word |
| right_word | output | 24 | Left-aligned right channel word |
| word_valid | output | 1 | One-cycle strobe for a new word pair |

## Verification
The checker watches four rules on every cycle: the strobe never lasts two cycles, the output words change only together with the strobe, 16-bit words arrive with zero low bits, and reset clears the outputs. Whether the right bits land in each word depends on the framing, the delay and the sampling edge, so only the bench's generated streams can show it. The bench covers every framing, each length, both slot sizes, the delay and the inverted clock. Its streams also carry junk bits outside each word, slots of the wrong size, and DSP frames too short to hold both words. The bench checks that these last cases produce no strobe and leave the previous words in place.

// File: rtl/serial_audio_rx_pkg.sv
package serial_audio_rx_pkg;

  typedef enum logic [1:0] {
    FMT_LJ  = 2'b00,
    FMT_I2S = 2'b01,
    FMT_RJ  = 2'b10,
    FMT_DSP = 2'b11
  } fmt_e;

  // word length in bits for a length code (R2)
  function automatic logic [4:0] word_len(input logic [1:0] code);
    case (code)
      2'b00:   return 5'd24;
      2'b01:   return 5'd20;
      2'b10:   return 5'd18;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/sfs_tracker.sv
// Frame-clock delay line, edge detection and bit position counter.
module sfs_tracker #(
  parameter int MAX_LAG = 2,
  parameter int CW      = 7,
  localparam int LW     = $clog2(MAX_LAG + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fs_in,
  input  logic [LW-1:0] lag,
  input  logic          rise_only,
  output logic          fs_edge,
  output logic          level_prev,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_now
);
  logic [MAX_LAG-1:0] dly;
  logic [MAX_LAG:0]   taps;
  logic               fs_eff;
  logic               fs_prev;

  assign taps   = {dly, fs_in};
  assign fs_eff = taps[lag];

  always_ff @(posedge clk) begin
    if (rst) begin
      dly     <= '0;
      fs_prev <= 1'b0;
      cnt_q   <= '1;
    end else begin
      dly     <= MAX_LAG'({dly, fs_in});
      fs_prev <= fs_eff;
      cnt_q   <= cnt_now;
    end
  end

  assign fs_edge    = rise_only ? (fs_eff & ~fs_prev) : (fs_eff ^ fs_prev);
  assign level_prev = fs_prev;
  assign cnt_now    = fs_edge ? '0 : ((cnt_q == '1) ? cnt_q : cnt_q + 1'b1);
endmodule

// File: rtl/bit_collector.sv
// Gated capture shifter plus a free-running history shifter.
module bit_collector #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         din,
  input  logic         take,
  output logic [W-1:0] cap_q,
  output logic [W-1:0] cap_d,
  output logic [W-1:0] hist_q
);
  assign cap_d = take ? {cap_q[W-2:0], din} : cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q  <= '0;
      hist_q <= '0;
    end else begin
      cap_q  <= cap_d;
      hist_q <= {hist_q[W-2:0], din};
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import serial_audio_rx_pkg::*;
#(
  parameter int OUT_W      = 24,
  parameter int SLOT_LONG  = 32,
  parameter int SLOT_SHORT = 24,
  parameter int MAX_LAG    = 2
) (
  input  logic             bclk,
  input  logic             rst,
  input  logic             sfs,
  input  logic             sdata,
  input  logic [1:0]       fmt_sel,
  input  logic [1:0]       len_sel,
  input  logic             short_frame,
  input  logic             fs_lag,
  input  logic             clk_flip,
  output logic [OUT_W-1:0] left_word,
  output logic [OUT_W-1:0] right_word,
  output logic             word_valid
);
  localparam int SPAN = (SLOT_LONG > OUT_W) ? SLOT_LONG : OUT_W;
  localparam int CW   = $clog2(2 * SPAN + 1);
  localparam int LW   = $clog2(MAX_LAG + 1);

  logic clk_int;
  assign clk_int = bclk ^ clk_flip;  // R9 sampling edge select

  logic is_dsp, is_i2s, is_rj, left_lvl;
  assign is_dsp   = (fmt_sel == FMT_DSP);
  assign is_i2s   = (fmt_sel == FMT_I2S);
  assign is_rj    = (fmt_sel == FMT_RJ);
  assign left_lvl = ~is_i2s;

  logic [CW-1:0] wlen, slot_len, dsp_last, take_lim;
  logic [CW-1:0] shamt;
  assign wlen     = CW'(word_len(len_sel));
  assign slot_len = short_frame ? CW'(SLOT_SHORT) : CW'(SLOT_LONG);
  assign dsp_last = (wlen << 1) - 1'b1;
  assign take_lim = is_dsp ? (wlen << 1) : wlen;
  assign shamt    = CW'(OUT_W) - wlen;

  // I2S is decoded as left-justified on a frame clock one bit later
  logic [LW-1:0] lag;
  assign lag = LW'(fs_lag) + LW'(is_i2s);

  logic          fs_edge, level_prev;
  logic [CW-1:0] cnt_q, cnt_now;

  sfs_tracker #(.MAX_LAG(MAX_LAG), .CW(CW)) u_sync (
    .clk(clk_int), .rst(rst), .fs_in(sfs), .lag(lag), .rise_only(is_dsp),
    .fs_edge(fs_edge), .level_prev(level_prev), .cnt_q(cnt_q), .cnt_now(cnt_now)
  );

  logic             take;
  logic [OUT_W-1:0] cap_q, cap_d, hist_q;
  assign take = (cnt_now < take_lim);

  bit_collector #(.W(OUT_W)) u_bits (
    .clk(clk_int), .rst(rst), .din(sdata), .take(take),
    .cap_q(cap_q), .cap_d(cap_d), .hist_q(hist_q)
  );

  logic             slot_ok;
  logic [OUT_W-1:0] end_word, end_aligned, dsp_aligned;
  assign slot_ok     = (cnt_q == slot_len - 1'b1);
  assign end_word    = is_rj ? hist_q : cap_q;
  assign end_aligned = end_word << shamt;
  assign dsp_aligned = cap_d << shamt;

  logic [OUT_W-1:0] hold_l;
  logic             have_l;

  always_ff @(posedge clk_int) begin
    if (rst) begin
      left_word  <= '0;
      right_word <= '0;
      word_valid <= 1'b0;
      hold_l     <= '0;
      have_l     <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (is_dsp) begin
        if (fs_edge) have_l <= 1'b0;
        if (cnt_now == wlen - 1'b1) begin
          hold_l <= dsp_aligned;
          have_l <= 1'b1;
        end
        if (cnt_now == dsp_last && have_l) begin
          left_word  <= hold_l;
          right_word <= dsp_aligned;
          word_valid <= 1'b1;
          have_l     <= 1'b0;
        end
      end else if (fs_edge) begin
        if (level_prev == left_lvl) begin
          have_l <= slot_ok;
          if (slot_ok) hold_l <= end_aligned;
        end else begin
          have_l <= 1'b0;
          if (slot_ok && have_l) begin
            left_word  <= hold_l;
            right_word <= end_aligned;
            word_valid <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
  parameter int OUT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       len_sel,
  input logic [OUT_W-1:0] left_word,
  input logic [OUT_W-1:0] right_word,
  input logic             word_valid
);
  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  assert_words_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !word_valid |-> ($stable(left_word) && $stable(right_word)));

  assert_zero_fill_R2: assert property (@(posedge clk) disable iff (rst)
    (word_valid && len_sel == 2'b11) |->
      (left_word[OUT_W-17:0] == '0 && right_word[OUT_W-17:0] == '0));

  assert_reset_clear_R13: assert property (@(posedge clk)
    rst |=> (!word_valid && left_word == '0 && right_word == '0));
endmodule

bind serial_audio_rx serial_audio_rx_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk_int), .rst(rst), .len_sel(len_sel),
  .left_word(left_word), .right_word(right_word), .word_valid(word_valid)
);

// File: tb/serial_audio_rx_bench.sv
`timescale 1ns/1ps
module serial_audio_rx_bench;
  logic        bclk = 1'b0;
  logic        rst = 1'b1;
  logic        sfs = 1'b0;
  logic        sdata = 1'b1;
  logic [1:0]  fmt_sel = 2'b00;
  logic [1:0]  len_sel = 2'b00;
  logic        short_frame = 1'b0;
  logic        fs_lag = 1'b0;
  logic        clk_flip = 1'b0;
  logic [23:0] left_word, right_word;
  logic        word_valid;

  always #2 bclk = ~bclk;

  serial_audio_rx u_serial_audio_rx (
    .bclk(bclk), .rst(rst), .sfs(sfs), .sdata(sdata), .fmt_sel(fmt_sel),
    .len_sel(len_sel), .short_frame(short_frame), .fs_lag(fs_lag),
    .clk_flip(clk_flip), .left_word(left_word), .right_word(right_word),
    .word_valid(word_valid)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // strobe monitor: samples 3 ns after each rising edge
  logic [23:0] rec_l [16];
  logic [23:0] rec_r [16];
  int rec_n = 0;
  always begin
    @(posedge bclk);
    #3;
    if (word_valid === 1'b1) begin
      if (rec_n < 16) begin
        rec_l[rec_n] = left_word;
        rec_r[rec_n] = right_word;
      end
      rec_n++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] word_of(input int seed, input int f, input int ch, input int w);
    int unsigned h;
    h = 32'(seed) * 32'd2654435761 + 32'((f * 2 + ch + 1)) * 32'd40503;
    h = h ^ (h >> 15);
    h = h * 32'd73244475;
    h = h ^ (h >> 12);
    return 24'(h & ((32'd1 << w) - 32'd1));
  endfunction

  function automatic logic gen_bit(input logic [1:0] fmt, input int w, input int s,
                                   input int tt, input int nfr, input int seed);
    int f, p, q;
    logic [23:0] lw, rw, wd;
    if (tt < 0) return 1'b1;
    f  = tt / (2 * s);
    p  = tt % (2 * s);
    lw = (f < nfr) ? word_of(seed, f, 0, w) : 24'd0;
    rw = (f < nfr) ? word_of(seed, f, 1, w) : 24'd0;
    if (fmt == 2'b11) begin
      if (p < w)     return lw[w-1-p];
      if (p < 2 * w) return rw[2*w-1-p];
      return 1'b1;
    end
    q  = p % s;
    wd = (p < s) ? lw : rw;
    if (fmt == 2'b10) return (q >= s - w) ? wd[s-1-q] : 1'b1;
    return (q < w) ? wd[w-1-q] : 1'b1;
  endfunction

  task automatic do_reset();
    @(posedge bclk); #1 rst = 1'b1;
    repeat (3) @(posedge bclk);
    #1 rst = 1'b0;
  endtask

  // stream nfr frames plus the start of one more, with slots of s bit clocks
  task automatic stream(input logic [1:0] fmt, input int w, input int s, input int lag,
                        input logic inv, input int nfr, input int seed);
    logic lvl, dsp, b;
    int tl, tot;
    lvl = (fmt == 2'b01) ? 1'b0 : 1'b1;
    dsp = (fmt == 2'b11);
    tl  = lag + ((fmt == 2'b01) ? 1 : 0);
    tot = nfr * 2 * s + s + 2;
    for (int i = 0; i < 4; i++) begin
      @(posedge bclk); #1;
      sfs = dsp ? 1'b0 : ~lvl;
      sdata = 1'b1;
    end
    for (int t = 0; t < tot; t++) begin
      @(posedge bclk); #1;
      if (dsp) sfs = ((t % (2 * s)) == 0);
      else     sfs = ((t % (2 * s)) < s) ? lvl : ~lvl;
      b = gen_bit(fmt, w, s, t - tl, nfr, seed);
      sdata = b;
      if (inv) begin
        #1.5;
        sdata = ~b;  // only the falling-edge sample sees the true bit
      end
    end
    @(posedge bclk); #1;
    sdata = 1'b1;
    repeat (3) @(posedge bclk);
    #1;
  endtask

  typedef struct packed {
    logic [1:0] fmt;
    logic [1:0] len;
    logic       f48;
    logic [6:0] gen_s;
    logic       lag;
    logic       inv;
    logic [3:0] nfr;
    logic [3:0] exp_n;
    logic [7:0] seed;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 2'b00, 1'b0, 7'd32, 1'b0, 1'b0, 4'd3, 4'd3, 8'd11, 8'd3},   // R1 R3 zero config
    '{2'b00, 2'b11, 1'b1, 7'd24, 1'b0, 1'b0, 4'd3, 4'd3, 8'd12, 8'd11},  // R2 R11 junk after 16 bits
    '{2'b01, 2'b00, 1'b1, 7'd24, 1'b0, 1'b0, 4'd3, 4'd3, 8'd13, 8'd4},   // R4 LSB on next slot edge
    '{2'b01, 2'b01, 1'b0, 7'd32, 1'b0, 1'b0, 4'd2, 4'd2, 8'd14, 8'd4},   // R4
    '{2'b10, 2'b10, 1'b0, 7'd32, 1'b0, 1'b0, 4'd3, 4'd3, 8'd15, 8'd5},   // R5 junk before word
    '{2'b10, 2'b00, 1'b1, 7'd24, 1'b0, 1'b0, 4'd2, 4'd2, 8'd16, 8'd5},   // R5
    '{2'b11, 2'b00, 1'b0, 7'd32, 1'b0, 1'b0, 4'd3, 4'd3, 8'd17, 8'd6},   // R6
    '{2'b11, 2'b11, 1'b1, 7'd24, 1'b1, 1'b0, 4'd3, 4'd3, 8'd18, 8'd8},   // R8 R6
    '{2'b00, 2'b01, 1'b0, 7'd32, 1'b1, 1'b0, 4'd2, 4'd2, 8'd19, 8'd8},   // R8
    '{2'b01, 2'b11, 1'b0, 7'd32, 1'b1, 1'b1, 4'd2, 4'd2, 8'd20, 8'd9},   // R9
    '{2'b10, 2'b01, 1'b1, 7'd24, 1'b0, 1'b1, 4'd2, 4'd2, 8'd21, 8'd9},   // R9
    '{2'b00, 2'b00, 1'b1, 7'd32, 1'b0, 1'b0, 4'd2, 4'd0, 8'd22, 8'd7},   // R7 long slots rejected
    '{2'b11, 2'b00, 1'b0, 7'd16, 1'b0, 1'b0, 4'd3, 4'd0, 8'd23, 8'd12},  // R12 DSP frame too short
    '{2'b00, 2'b10, 1'b0, 7'd24, 1'b0, 1'b0, 4'd2, 4'd0, 8'd24, 8'd7}    // R7 short slots rejected
  };

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    string rq;
    logic [23:0] el, er;
    // R13 reset state, R1 all-zero configuration
    do_reset();
    check(word_valid == 1'b0, "R13", "valid after reset", 32'(word_valid), 0);
    check(left_word == 24'd0, "R13", "left after reset", 32'(left_word), 0);
    check(right_word == 24'd0, "R13", "right after reset", 32'(right_word), 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int w;
      v = VECS[i];
      w = int'(serial_audio_rx_pkg::word_len(v.len));
      rq = $sformatf("R%0d", v.req);
      @(posedge bclk); #1;
      fmt_sel = v.fmt; len_sel = v.len; short_frame = v.f48;
      fs_lag = v.lag; clk_flip = v.inv;
      do_reset();
      rec_n = 0;
      stream(v.fmt, w, int'(v.gen_s), int'(v.lag), v.inv, int'(v.nfr), int'(v.seed));
      check(rec_n == int'(v.exp_n), "R10", $sformatf("vector %0d strobe count (%s)", i, rq),
            32'(rec_n), 32'(v.exp_n));
      for (int k = 0; k < int'(v.exp_n) && k < rec_n; k++) begin
        el = word_of(int'(v.seed), k, 0, w) << (24 - w);
        er = word_of(int'(v.seed), k, 1, w) << (24 - w);
        check(rec_l[k] == el, rq, $sformatf("vector %0d frame %0d left", i, k),
              32'(rec_l[k]), 32'(el));
        check(rec_r[k] == er, rq, $sformatf("vector %0d frame %0d right", i, k),
              32'(rec_r[k]), 32'(er));
      end
      if (v.exp_n == 0) begin
        check(left_word == 24'd0 && right_word == 24'd0, "R12",
              $sformatf("vector %0d words untouched", i), 32'(left_word), 0);
      end
    end

    // R12: a good frame, then mismatched slots keep the old words
    @(posedge bclk); #1;
    fmt_sel = 2'b00; len_sel = 2'b00; short_frame = 1'b0; fs_lag = 1'b0; clk_flip = 1'b0;
    do_reset();
    rec_n = 0;
    stream(2'b00, 24, 32, 0, 1'b0, 1, 77);
    check(rec_n == 1, "R12", "good frame strobes once", 32'(rec_n), 1);
    short_frame = 1'b1;
    stream(2'b00, 24, 32, 0, 1'b0, 2, 78);
    el = word_of(77, 0, 0, 24);
    er = word_of(77, 0, 1, 24);
    check(rec_n == 1, "R12", "bad slots give no strobe", 32'(rec_n), 1);
    check(left_word == el, "R12", "left word kept", 32'(left_word), 32'(el));
    check(right_word == er, "R12", "right word kept", 32'(right_word), 32'(er));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule